// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers up to sixteen single-cycle event pulses into two 8-bit sticky flag registers. It drives one active-high interrupt request line to a host. Each event has its own enable bit, held in two 8-bit enable registers. A flag records its event whether or not the enable is set. The enable decides only whether that flag takes part in the interrupt request.

The host reaches the four registers over a simple register bus: address, write strobe, write data and read data. On an interrupt, the host reads the flag registers to find which events fired. It then clears the flags it has handled by writing ones back to the same addresses. The interrupt request is the OR of every flag ANDed with its enable. It is held in a register that follows the flag and enable state on the same clock edge that changes them.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, both flag registers, both enable registers and `irq_o` are all zero.
- R2: A pulse on `evt_i[k]` sets a flag bit at the next rising clock edge. Events 0..7 appear as bits 0..7 of the register at address E8h. Events 8..15 appear as bits 0..7 of the register at address E9h.
- R3: A write to E8h or E9h clears every flag bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: When an event pulse arrives in the same cycle as a write that clears its flag, the flag stays set.
- R5: Flags latch their events whatever the state of the enable bits.
- R6: The enable register at EAh holds the enables for events 0..7, and EBh holds those for events 8..15. A read returns the last value written, and a write takes effect at the next clock edge.
- R7: `irq_o` is high exactly when some flag bit and its enable bit are both 1. It rises at the same clock edge at which an enabled flag is captured or an enable bit for a set flag is written.
- R8: `irq_o` falls at the clock edge of the write that clears the last enabled flag, or of the write that masks it.
- R9: A read from any address other than E8h..EBh returns zero, and a write to such an address changes no flag or enable.
- R10: A set flag stays set until it is cleared by a write, even after its event input returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 16 | Event pulses, one bit per event |
| reg_addr_i | input | 8 | Register bus address |
| reg_wr_i | input | 1 | Register bus write strobe |
| reg_wdata_i | input | 8 | Register bus write data |
| reg_rdata_o | output | 8 | Register bus read data, combinational from the address |
| irq_o | output | 1 | Interrupt request, active high, registered |

## Verification
The assertions assume that `evt_i`, `reg_addr_i`, `reg_wr_i` and `reg_wdata_i` are synchronous to `clk` and stable around its rising edge. They also assume the write strobe is meaningful only for one cycle per access. The bench changes every input on the falling edge and returns the strobe and events to zero one cycle later. It reads registers only while no write or event is active, so each read sees settled state. The random phase draws addresses from the four mapped registers plus one unmapped address. This keeps the decoder within the cases its one-hot check expects.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
package irq_flag_pkg;
  localparam int BANK_W_DEF    = 8;
  localparam int NUM_BANKS_DEF = 2;
  localparam int ADDR_W_DEF    = 8;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_FLAG = 2'd1,
    REG_MASK = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
  import irq_flag_pkg::*;
#(
  parameter int                ADDR_W    = ADDR_W_DEF,
  parameter int                NUM_BANKS = NUM_BANKS_DEF,
  parameter logic [ADDR_W-1:0] FLAG_BASE = 8'hE8,
  parameter logic [ADDR_W-1:0] MASK_BASE = 8'hEA
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] flag_hit_o,
  output logic [NUM_BANKS-1:0] mask_hit_o,
  output reg_kind_e            kind_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FLAG_BASE + b);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_BASE + b);
    assign flag_hit_o[b] = (addr_i == FLAG_ADDR);
    assign mask_hit_o[b] = (addr_i == MASK_ADDR);
  end

  always_comb begin
    if (|flag_hit_o)      kind_o = REG_FLAG;
    else if (|mask_hit_o) kind_o = REG_MASK;
    else                  kind_o = REG_NONE;
  end
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         wr_i,
  input  logic         flag_sel_i,
  input  logic         mask_sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_q_o,
  output logic [W-1:0] flag_d_o,
  output logic [W-1:0] mask_q_o,
  output logic [W-1:0] mask_d_o
);
  logic [W-1:0] flag_q, flag_d;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] clr_mask;
  logic         flag_ce, mask_ce;

  // Next state: set has priority over clear.
  always_comb begin
    clr_mask = (wr_i && flag_sel_i) ? wdata_i : '0;
    flag_d   = (flag_q & ~clr_mask) | evt_i;
    flag_ce  = (|clr_mask) || (|evt_i);
    mask_ce  = wr_i && mask_sel_i;
    mask_d   = mask_ce ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      if (flag_ce) flag_q <= flag_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end

  assign flag_q_o = flag_q;
  assign flag_d_o = flag_d;
  assign mask_q_o = mask_q;
  assign mask_d_o = mask_d;

  AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~flag_q) & $past(flag_q) & ~$past(clr_mask)) == '0)); // R10
  AST_CLR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && flag_sel_i) |=> (((~flag_q) & $past(flag_q)) == '0)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && mask_sel_i) |=> $stable(mask_q)); // R6
endmodule

// File: rtl/irq_req_gen.sv
`timescale 1ns/1ps
module irq_req_gen #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_d_i,
  input  logic [N-1:0] mask_d_i,
  input  logic [N-1:0] flag_q_i,
  input  logic [N-1:0] mask_q_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = |(flag_d_i & mask_d_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|(flag_q_i & mask_q_i))); // R7
  AST_IRQ_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q_i & mask_q_i) == '0) |-> !irq_q); // R8
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int                ADDR_W    = ADDR_W_DEF,
  parameter int                BANK_W    = BANK_W_DEF,
  parameter int                NUM_BANKS = NUM_BANKS_DEF,
  parameter logic [ADDR_W-1:0] FLAG_BASE = 8'hE8,
  parameter logic [ADDR_W-1:0] MASK_BASE = 8'hEA
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   evt_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic                          reg_wr_i,
  input  logic [BANK_W-1:0]             reg_wdata_i,
  output logic [BANK_W-1:0]             reg_rdata_o,
  output logic                          irq_o
);
  localparam int N_EVT = NUM_BANKS * BANK_W;

  logic                 rst_sync_n;
  logic [NUM_BANKS-1:0] flag_hit, mask_hit;
  reg_kind_e            kind;
  logic [N_EVT-1:0]     flag_q, flag_d, mask_q, mask_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_reg_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS),
    .FLAG_BASE (FLAG_BASE),
    .MASK_BASE (MASK_BASE)
  ) u_dec (
    .addr_i     (reg_addr_i),
    .flag_hit_o (flag_hit),
    .mask_hit_o (mask_hit),
    .kind_o     (kind)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_flag_bank #(.W(BANK_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .evt_i      (evt_i[b*BANK_W +: BANK_W]),
      .wr_i       (reg_wr_i),
      .flag_sel_i (flag_hit[b]),
      .mask_sel_i (mask_hit[b]),
      .wdata_i    (reg_wdata_i),
      .flag_q_o   (flag_q[b*BANK_W +: BANK_W]),
      .flag_d_o   (flag_d[b*BANK_W +: BANK_W]),
      .mask_q_o   (mask_q[b*BANK_W +: BANK_W]),
      .mask_d_o   (mask_d[b*BANK_W +: BANK_W])
    );
  end

  irq_req_gen #(.N(N_EVT)) u_req (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flag_d_i (flag_d),
    .mask_d_i (mask_d),
    .flag_q_i (flag_q),
    .mask_q_i (mask_q),
    .irq_o    (irq_o)
  );

  // Read mux: the decoder gives at most one hit.
  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (kind == REG_FLAG && flag_hit[b]) reg_rdata_o = reg_rdata_o | flag_q[b*BANK_W +: BANK_W];
      if (kind == REG_MASK && mask_hit[b]) reg_rdata_o = reg_rdata_o | mask_q[b*BANK_W +: BANK_W];
    end
  end

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({flag_hit, mask_hit})); // R9
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (kind == REG_NONE) |-> (reg_rdata_o == '0)); // R9
  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_i && kind == REG_NONE && evt_i == '0) |=> ($stable(flag_q) && $stable(mask_q))); // R9
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] evt_i;
  logic [7:0]  reg_addr_i;
  logic        reg_wr_i;
  logic [7:0]  reg_wdata_i;
  logic [7:0]  reg_rdata_o;
  logic        irq_o;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] rdata;
    logic       irq;
    string      req;
  } exp_t;

  exp_t  sb_q[$];
  event  sample_ev;
  int    n_cmp  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  logic [15:0] m_flag;
  logic [15:0] m_mask;

  irq_flag_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'hE8:   return m_flag[7:0];
      8'hE9:   return m_flag[15:8];
      8'hEA:   return m_mask[7:0];
      8'hEB:   return m_mask[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // Driver: one bus/event cycle, then the reference state is updated from the requirements.
  task automatic do_cycle(input logic [15:0] ev, input logic wr, input logic [7:0] a, input logic [7:0] d);
    logic [15:0] clr;
    @(negedge clk);
    evt_i = ev; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk);
    clr = '0;
    if (wr && a == 8'hE8) clr[7:0]  = d;
    if (wr && a == 8'hE9) clr[15:8] = d;
    m_flag = (m_flag & ~clr) | ev;
    if (wr && a == 8'hEA) m_mask[7:0]  = d;
    if (wr && a == 8'hEB) m_mask[15:8] = d;
    @(negedge clk);
    evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  // Driver side of the scoreboard: push the expected item, then hand over to the monitor.
  task automatic check_reg(input logic [7:0] a, input string req);
    exp_t it;
    @(negedge clk);
    reg_addr_i = a;
    #0.5;
    it.addr = a; it.rdata = model_read(a); it.irq = |(m_flag & m_mask); it.req = req;
    sb_q.push_back(it);
    -> sample_ev;
    #0.5;
  endtask

  task automatic check_all(input string req);
    check_reg(8'hE8, req);
    check_reg(8'hE9, req);
    check_reg(8'hEA, req);
    check_reg(8'hEB, req);
  endtask

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      exp_t it;
      @(sample_ev);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_cmp++;
        if (reg_rdata_o !== it.rdata || irq_o !== it.irq) begin
          n_fail++;
          $display("FAIL %s addr=%02h: rdata=%02h irq=%0b, expected rdata=%02h irq=%0b",
                   it.req, it.addr, reg_rdata_o, irq_o, it.rdata, it.irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [5];
    addrs[0] = 8'hE8; addrs[1] = 8'hE9; addrs[2] = 8'hEA; addrs[3] = 8'hEB; addrs[4] = 8'hEC;
    m_flag = '0; m_mask = '0;
    evt_i = '0; reg_wr_i = 1'b0; reg_addr_i = 8'h00; reg_wdata_i = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    check_all("R1");                              // R1 reset state
    check_reg(8'h00, "R9");                       // R9 unmapped read
    check_reg(8'hFF, "R9");

    do_cycle(16'h8001, 1'b0, 8'h00, 8'h00);       // R2 events 0 and 15, R5 with masks clear
    check_reg(8'hE8, "R2");
    check_reg(8'hE9, "R2");
    check_reg(8'hE8, "R5");                       // R5 irq must stay low
    check_all("R10");                             // R10 events gone, flags held

    do_cycle(16'h0000, 1'b1, 8'hEA, 8'h01);       // R7 enabling a set flag raises irq
    check_reg(8'hEA, "R7");
    do_cycle(16'h0000, 1'b1, 8'hEB, 8'h5A);       // R6 mask readback
    check_reg(8'hEB, "R6");
    check_reg(8'hEA, "R6");

    do_cycle(16'h0000, 1'b1, 8'hE8, 8'h00);       // R3 zero write leaves flags
    check_reg(8'hE8, "R3");
    do_cycle(16'h0000, 1'b1, 8'hE8, 8'h01);       // R3 and R8: clear the last enabled flag
    check_reg(8'hE8, "R3");
    check_reg(8'hE9, "R8");

    do_cycle(16'h0200, 1'b0, 8'h00, 8'h00);       // R7 enabled event 9 raises irq
    check_reg(8'hE9, "R7");
    do_cycle(16'h0000, 1'b1, 8'hEB, 8'h00);       // R8 masking drops irq
    check_reg(8'hEB, "R8");
    do_cycle(16'h0000, 1'b1, 8'hEB, 8'h02);
    check_reg(8'hE9, "R7");

    do_cycle(16'h0200, 1'b1, 8'hE9, 8'h02);       // R4 set beats clear
    check_reg(8'hE9, "R4");

    do_cycle(16'h0000, 1'b1, 8'hEC, 8'hFF);       // R9 unmapped write is inert
    check_all("R9");
    do_cycle(16'h0000, 1'b1, 8'h10, 8'hFF);
    check_all("R9");

    do_cycle(16'h0000, 1'b1, 8'hE9, 8'hFF);       // R3 and R8: clear all of bank 1
    check_all("R8");

    for (int i = 0; i < 60; i++) begin            // R7 mixed traffic
      logic [15:0] ev;
      logic [7:0]  a;
      ev = 16'($urandom) & 16'($urandom) & 16'($urandom);
      a  = addrs[$urandom % 5];
      do_cycle(ev, 1'($urandom), a, 8'($urandom));
      check_all("R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule